// File: doc/BRIEF.md
# Current-DAC Update Scheduler

This block is the digital front end of a 10-bit current-output converter. Software reaches it over a byte-wide register bus that has three registers: a control register, a low data byte and a high data byte. Data writes land in holding registers. A separate output latch drives the converter code. The block decides when the held code is copied into that latch.

The copy can happen on one of three events. The first is a high-byte write, which is the reset default. The second is the overflow pulse of one selected timer out of four. The third is a chosen edge polarity on an external pin, which is first passed through a synchronizer. Because of this, waveform samples can be preloaded and then released at exact instants.

The block also drives the converter enable, a pin-override signal, and a 2-bit full-scale current select. The override tells the pad to turn off its digital driver and pull-up and to connect the pin to the analog output.

Top module: `dac_update_sched`

## Requirements
- R1: After reset, dac_code is 0, dac_en and pin_override are 0, fs_sel is 00, and the control register reads 0x70. This means the update mode is 111.
- R2: Register map: address 0 is control, with bit 7 as enable, bits [6:4] as update mode, bits [1:0] as full-scale, and bits [3:2] reading 0. Address 1 is the low byte, where only bits [7:6] are stored and the other bits read 0. Address 2 is the high byte, with all 8 bits stored. Address 3 reads 0.
- R3: In mode 111, a write of value H to address 2 makes dac_code equal {H, held low[7:6]} right after that clock edge. A write to address 1 alone leaves dac_code unchanged.
- R4: 8-bit use: with the low byte preset to 0x00, each high-byte write H gives dac_code = 4*H.
- R5: Modes 000 to 011 select timer 0 to timer 3. A pulse on tmr_ovf[n] sampled at edge k loads the held code into dac_code at edge k+1. Pulses on the other timers are ignored.
- R6: Modes 100, 101 and 110 load on a rising edge, a falling edge, or either edge of ext_pin. The code changes at the (SYNC_STAGES+2)th clock edge after the pin changes, which is the 4th edge by default. An edge of the other polarity is ignored.
- R7: In modes 000 to 110, writes to either data byte change only the holding registers and never dac_code. Each trigger loads the held code, and a trigger with no new write reloads the same code.
- R8: If a trigger load and a data write fall on the same clock edge, the latch takes the code held before that write. The written value is used from the next trigger onward.
- R9: dac_en and pin_override both follow control bit 7, and fs_sel follows control bits [1:0].
- R10: In mode 111, timer pulses and ext_pin edges never change dac_code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tmr_ovf | input | 4 | Timer overflow pulses, one per timer |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| dac_code | output | 10 | Output latch driving the converter |
| dac_en | output | 1 | Converter enable |
| pin_override | output | 1 | Pad digital driver/pull-up off, pin routed to converter |
| fs_sel | output | 2 | Full-scale current select (00, 01, 10 = lowest to highest) |

## Verification
Two functions can land on the same clock edge: a scheduled trigger load of the output latch, and a bus write into the holding registers. The bench provokes this by pulsing a timer overflow and placing a high-byte write with a new value exactly one cycle later, which is the edge where the latch loads. The check passes only if dac_code shows the previously held code at that edge and shows the new value only after a second trigger.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 10;
  localparam int LO_BITS = CODE_W - BYTE_W;
  localparam int NUM_TMR = 4;
  localparam int ADDR_W  = 2;

  typedef enum logic [2:0] {
    M_TMR0 = 3'd0,
    M_TMR1 = 3'd1,
    M_TMR2 = 3'd2,
    M_TMR3 = 3'd3,
    M_RISE = 3'd4,
    M_FALL = 3'd5,
    M_BOTH = 3'd6,
    M_HIWR = 3'd7
  } upd_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd2;

  function automatic logic [CODE_W-1:0] join_code(input logic [BYTE_W-1:0] hi,
                                                   input logic [LO_BITS-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] lo_view(input logic [LO_BITS-1:0] lo);
    return {lo, {(BYTE_W-LO_BITS){1'b0}}};
  endfunction

  function automatic logic [BYTE_W-1:0] ctrl_view(input logic en, input upd_mode_e m,
                                                  input logic [1:0] fs);
    return {en, m, 2'b00, fs};
  endfunction
endpackage

// File: rtl/dacu_regs.sv
module dacu_regs
  import dacu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [BYTE_W-1:0]    rd_data,
  output logic                 en,
  output upd_mode_e            mode,
  output logic [1:0]           fs,
  output logic [BYTE_W-1:0]    hold_hi,
  output logic [LO_BITS-1:0]   hold_lo,
  output logic                 hi_wr
);
  logic ctrl_wr, lo_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign lo_wr   = wr_en && (wr_addr == A_LO);
  assign hi_wr   = wr_en && (wr_addr == A_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      mode    <= M_HIWR;
      fs      <= 2'b00;
      hold_hi <= '0;
      hold_lo <= '0;
    end else begin
      if (ctrl_wr) begin
        en   <= wr_data[7];
        mode <= upd_mode_e'(wr_data[6:4]);
        fs   <= wr_data[1:0];
      end
      if (lo_wr) hold_lo <= wr_data[BYTE_W-1 -: LO_BITS];
      if (hi_wr) hold_hi <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_view(en, mode, fs);
      A_LO:    rd_data = lo_view(hold_lo);
      A_HI:    rd_data = hold_hi;
      default: rd_data = '0;
    endcase
  end

  // R2: a low-byte write updates only the stored top bits, visible on readback
  assert_lo_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> hold_lo == $past(wr_data[BYTE_W-1 -: LO_BITS]));
endmodule

// File: rtl/dacu_trig.sv
module dacu_trig
  import dacu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  upd_mode_e          mode,
  input  logic [NUM_TMR-1:0] tmr_ovf,
  input  logic               ext_pin,
  output logic               trig_q
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]    sh;
  logic               pin_now, pin_prev;
  logic               edge_rise, edge_fall;
  logic [NUM_TMR-1:0] tmr_hit;
  logic               pin_hit;
  logic [NUM_TMR:0]   src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], ext_pin};
  end

  assign pin_now   = sh[SYNC_STAGES-1];
  assign pin_prev  = sh[SYNC_STAGES];
  assign edge_rise = pin_now && !pin_prev;
  assign edge_fall = !pin_now && pin_prev;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign tmr_hit[i] = tmr_ovf[i] && (mode == upd_mode_e'(i));
  end

  always_comb begin
    case (mode)
      M_RISE:  pin_hit = edge_rise;
      M_FALL:  pin_hit = edge_fall;
      M_BOTH:  pin_hit = edge_rise || edge_fall;
      default: pin_hit = 1'b0;
    endcase
  end

  assign src = {pin_hit, tmr_hit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= |src;
  end

  // R5: at most one trigger source is active in any cycle
  assert_one_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src));
  // R5: selected timer pulse arms the load for the next edge
  assert_tmr_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_hit) |=> trig_q);
  // R10: in high-byte mode nothing arms a trigger
  assert_hiwr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HIWR) |=> !trig_q);
endmodule

// File: rtl/dac_update_sched.sv
module dac_update_sched
  import dacu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic [1:0]   rd_addr,
  output logic [7:0]   rd_data,
  input  logic [3:0]   tmr_ovf,
  input  logic         ext_pin,
  output logic [9:0]   dac_code,
  output logic         dac_en,
  output logic         pin_override,
  output logic [1:0]   fs_sel
);
  logic                en;
  upd_mode_e           mode;
  logic [1:0]          fs;
  logic [BYTE_W-1:0]   hold_hi;
  logic [LO_BITS-1:0]  hold_lo;
  logic                hi_wr;
  logic                trig_q;
  logic                hi_load, trig_load;
  logic [CODE_W-1:0]   code_q;

  dacu_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .en(en), .mode(mode), .fs(fs),
    .hold_hi(hold_hi), .hold_lo(hold_lo), .hi_wr(hi_wr)
  );

  dacu_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tmr_ovf(tmr_ovf),
    .ext_pin(ext_pin), .trig_q(trig_q)
  );

  assign hi_load   = hi_wr && (mode == M_HIWR);
  assign trig_load = trig_q && !hi_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_q <= '0;
    else if (hi_load)   code_q <= join_code(wr_data, hold_lo);
    else if (trig_load) code_q <= join_code(hold_hi, hold_lo);
  end

  assign dac_code     = code_q;
  assign dac_en       = en;
  assign pin_override = en;
  assign fs_sel       = fs;

  // R3: with no load event, the output latch holds still
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_load || trig_load) |=> $stable(dac_code));
  // R3: high-byte write combines the new byte with the held low bits
  assert_hiwr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> dac_code == {$past(wr_data), $past(hold_lo)});
  // R8: trigger loads the code held before any write on the same edge
  assert_trig_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_load |=> dac_code == {$past(hold_hi), $past(hold_lo)});
  // R7: in trigger modes the bus never loads the latch directly
  assert_no_bus_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_HIWR && !trig_q) |=> $stable(dac_code));
endmodule

// File: tb/dac_update_sched_tb.sv
module dac_update_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] tmr_ovf = '0;
  logic       ext_pin = 1'b0;
  logic [9:0] dac_code;
  logic       dac_en, pin_override;
  logic [1:0] fs_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dac_update_sched u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
    .dac_code(dac_code), .dac_en(dac_en), .pin_override(pin_override), .fs_sel(fs_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic tpulse(input int n);
    @(negedge clk);
    tmr_ovf = 4'(1 << n);
    @(negedge clk);
    tmr_ovf = '0;
  endtask

  function automatic int expect_code(input int hi, input int lo);
    return hi * 4 + (lo / 64);
  endfunction

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 code", dac_code, 0);
    chk("R1 en", dac_en, 0);
    chk("R1 ovr", pin_override, 0);
    chk("R1 fs", fs_sel, 0);
    rd(2'd0, r); chk("R1 ctrl", r, 8'h70);

    // R2 register map and readback
    wr(2'd1, 8'hFF); rd(2'd1, r); chk("R2 lo", r, 8'hC0);
    wr(2'd2, 8'hA5); rd(2'd2, r); chk("R2 hi", r, 8'hA5);
    wr(2'd3, 8'hFF); rd(2'd3, r); chk("R2 addr3", r, 0);
    wr(2'd0, 8'hFF); rd(2'd0, r); chk("R2 ctrl", r, 8'hF3);
    // R9 enable and full-scale pass-through
    chk("R9 en", dac_en, 1); chk("R9 ovr", pin_override, 1); chk("R9 fs", fs_sel, 3);
    for (int f = 0; f < 3; f++) begin
      wr(2'd0, 8'(8'h70 | f)); chk("R9 fs sweep", fs_sel, f); chk("R9 en off", dac_en, 0);
    end

    // R3 exhaustive sweep of codes in high-byte mode
    for (int c = 0; c < 1024; c++) begin
      wr(2'd1, 8'((c % 4) * 64));
      held = dac_code;
      chk("R3 lo held", dac_code, held);
      wr(2'd2, 8'(c / 4));
      chk("R3 hi load", dac_code, expect_code(c / 4, (c % 4) * 64));
    end
    wr(2'd1, 8'h40);
    chk("R3 lo alone", dac_code, 1023);

    // R4 8-bit operation
    wr(2'd1, 8'h00);
    for (int h = 0; h < 256; h += 17) begin
      wr(2'd2, 8'(h)); chk("R4 8bit", dac_code, h * 4);
    end

    // R10 triggers ignored in high-byte mode
    held = dac_code;
    for (int n = 0; n < 4; n++) begin
      tpulse(n); @(negedge clk); chk("R10 tmr", dac_code, held);
    end
    ext_pin = 1'b1; repeat (6) @(negedge clk); chk("R10 pin", dac_code, held);
    ext_pin = 1'b0; repeat (6) @(negedge clk);

    // R5 / R7 timer modes: each mode against each timer
    for (int m = 0; m < 4; m++) begin
      wr(2'd0, 8'(m << 4));
      for (int n = 0; n < 4; n++) begin
        int hv = (m * 4 + n) * 13 + 1;
        held = dac_code;
        wr(2'd1, 8'h80); wr(2'd2, 8'(hv));
        chk("R7 bus no load", dac_code, held);
        tpulse(n);
        chk("R5 not yet", dac_code, held);
        @(negedge clk);
        if (n == m) chk("R5 selected", dac_code, expect_code(hv, 8'h80));
        else        chk("R5 ignored", dac_code, held);
      end
      tpulse(m); @(negedge clk);
      held = dac_code;
      tpulse(m); @(negedge clk); chk("R7 reload", dac_code, held);
    end

    // R8 trigger load coinciding with a write
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h00); wr(2'd2, 8'h11);
    tpulse(1); @(negedge clk); chk("R8 setup", dac_code, 8'h11 * 4);
    @(negedge clk); tmr_ovf = 4'b0010;
    @(negedge clk); tmr_ovf = '0; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h22;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 old value", dac_code, 8'h11 * 4);
    tpulse(1); @(negedge clk); chk("R8 new value", dac_code, 8'h22 * 4);

    // R6 edge modes: mode 4 rise, 5 fall, 6 both
    for (int m = 4; m < 7; m++) begin
      wr(2'd0, 8'(m << 4));
      for (int e = 0; e < 2; e++) begin
        logic fires;
        int hv = m * 20 + e * 7 + 3;
        held = dac_code;
        wr(2'd2, 8'(hv));
        fires = (m == 6) || (m == 4 && e == 0) || (m == 5 && e == 1);
        @(negedge clk); ext_pin = (e == 0);
        repeat (3) @(negedge clk);
        chk("R6 latency", dac_code, held);
        @(negedge clk);
        chk(fires ? "R6 edge load" : "R6 wrong edge", dac_code,
            fires ? expect_code(hv, 0) : held);
        repeat (2) @(negedge clk);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule